// File: doc/BRIEF.md
# Three-stage common-mode suppression unit

This block cleans one event of strip-detector samples before zero suppression. Each 6-bit ADC code arrives with its channel index. The block subtracts that channel's stored pedestal and keeps the signed result in a per-channel store. Once the last channel of the event has arrived, the block scans the store several times, one channel per clock. These scans estimate a common-mode offset in three refinement stages, count how many signal channels the correction would recover, and then stream out the corrected values together with a per-channel hit flag.

The first stage averages channels that fall inside a coarse window. This window reaches twice as far below zero as above it. The second and third stages average only the channels whose residual against the previous estimate stays inside a small symmetric window. The block drops the correction and uses a common mode of zero in three cases: suppression is switched off, the last stage used too few channels, or too many channels would be recovered. Pedestals, per-channel thresholds and kill bits are written through a configuration port at initialization. The global window widths and gate limits are static inputs.

Top module: `cms_unit`

## Requirements
- R1: With suppression disabled (cms_en_i = 0), each channel's output equals its ADC code minus its pedestal, as an 8-bit two's-complement value.
- R2: A channel whose kill bit is 1 outputs value 0 and hit 0. It is left out of every stage average and of every counter.
- R3: Stage 1 selects channels with value d where -2*th1 <= d <= th1. A stage estimate is the sum of the selected values divided by their count, truncated toward zero, and it is 0 when no channel is selected.
- R4: Stage 2 selects channels with |d - CM1| <= th2 and stage 3 selects channels with |d - CM2| <= th3. n3_o reports the number of channels that stage 3 selected.
- R5: nrec_o counts the live channels for which d <= thr and d - CM3 > thr.
- R6: cm_o equals CM3 when cms_en_i = 1, n3 >= ncm_i and nrec <= nrec_i. Otherwise cm_o is 0. The block subtracts cm_o from every channel.
- R7: Each channel outputs d - cm_o, saturated to 8 bits signed. out_hit_o is 1 when that value is greater than the channel's unsigned 6-bit threshold. nsig_o counts the hits.
- R8: Samples are accepted only while busy_o is 0, in any channel order. The sample for channel 127 ends the event and raises busy_o on the next cycle. Samples presented while busy_o is 1 are ignored.
- R9: Results leave one per clock in ascending channel order, marked by out_valid_o. done_o is a one-cycle pulse that coincides with channel 127's output. cm_o, n3_o, nrec_o and nsig_o stay at their values until the next done_o.
- R10: After reset, busy_o, out_valid_o, done_o and all counters and cm_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write one channel's configuration |
| cfg_ch_i | input | 7 | Channel being configured |
| cfg_ped_i | input | 6 | Pedestal |
| cfg_thr_i | input | 6 | Per-channel hit threshold |
| cfg_kill_i | input | 1 | Kill bit |
| cms_en_i | input | 1 | Enable common-mode suppression |
| th1_i | input | 6 | Stage 1 window width |
| th2_i | input | 6 | Stage 2 window half-width |
| th3_i | input | 6 | Stage 3 window half-width |
| thr_i | input | 6 | Recovery threshold |
| ncm_i | input | 8 | Minimum stage 3 channel count |
| nrec_i | input | 8 | Maximum recovered count |
| smp_valid_i | input | 1 | Sample strobe |
| smp_ch_i | input | 7 | Sample channel |
| smp_adc_i | input | 6 | Sample ADC code |
| busy_o | output | 1 | Event in processing |
| out_valid_o | output | 1 | Output channel valid |
| out_ch_o | output | 7 | Output channel index |
| out_data_o | output | 8 | Corrected signed value |
| out_hit_o | output | 1 | Hit flag |
| done_o | output | 1 | Event complete pulse |
| cm_o | output | 8 | Applied common mode, signed |
| n3_o | output | 8 | Stage 3 channel count |
| nsig_o | output | 8 | Hit count |
| nrec_o | output | 8 | Recovered count |

## Verification
The assertions watch the following on every cycle:
- done_o lasting exactly one cycle;
- output channels rising strictly in order;
- a hit never carrying a non-positive value;
- a zero common mode whenever the gate conditions call for it;
- n3_o staying within the channel count;
- the divider returning zero for an empty selection.

Only the bench scenarios can show the arithmetic itself, by comparing against an independent model. This covers the asymmetric first window, the two refinement stages and truncation of negative averages. It also covers the recovered-channel count, whose value is pushed to either side of the gate limit. Ignored samples during processing, out-of-order capture, kill masking and the all-killed and nothing-selected cases are likewise shown only by those scenarios.

// File: rtl/cms_pkg.sv
package cms_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_P1, ST_D1, ST_P2, ST_D2, ST_P3, ST_D3, ST_REC, ST_DEC, ST_OUT
  } cms_state_e;

  // window selection flavour seen by the per-channel evaluator
  typedef enum logic {
    SEL_COARSE,
    SEL_SYMM
  } sel_mode_e;
endpackage

// File: rtl/cms_chan_store.sv
module cms_chan_store #(
  parameter int NCH   = 128,
  parameter int ADC_W = 6,
  localparam int IDX_W = $clog2(NCH),
  localparam int DAT_W = ADC_W + 1
) (
  input  logic                    clk_i,
  input  logic                    cfg_we_i,
  input  logic [IDX_W-1:0]        cfg_ch_i,
  input  logic [ADC_W-1:0]        cfg_ped_i,
  input  logic [ADC_W-1:0]        cfg_thr_i,
  input  logic                    cfg_kill_i,
  input  logic                    smp_we_i,
  input  logic [IDX_W-1:0]        smp_ch_i,
  input  logic [ADC_W-1:0]        smp_adc_i,
  input  logic [IDX_W-1:0]        rd_idx_i,
  output logic signed [DAT_W-1:0] rd_dat_o,
  output logic [ADC_W-1:0]        rd_thr_o,
  output logic                    rd_kill_o
);
  logic [ADC_W-1:0]        ped_mem [NCH];
  logic [ADC_W-1:0]        thr_mem [NCH];
  logic                    kill_mem[NCH];
  logic signed [DAT_W-1:0] dat_mem [NCH];

  logic signed [DAT_W-1:0] sub_d;
  assign sub_d = $signed({1'b0, smp_adc_i}) - $signed({1'b0, ped_mem[smp_ch_i]});

  always_ff @(posedge clk_i) begin
    if (cfg_we_i) begin
      ped_mem[cfg_ch_i]  <= cfg_ped_i;
      thr_mem[cfg_ch_i]  <= cfg_thr_i;
      kill_mem[cfg_ch_i] <= cfg_kill_i;
    end
    if (smp_we_i) dat_mem[smp_ch_i] <= sub_d;
  end

  assign rd_dat_o  = dat_mem[rd_idx_i];
  assign rd_thr_o  = thr_mem[rd_idx_i];
  assign rd_kill_o = kill_mem[rd_idx_i];
endmodule

// File: rtl/cms_chan_eval.sv
module cms_chan_eval import cms_pkg::*; #(
  parameter int ADC_W = 6,
  parameter int CM_W  = 8,
  parameter int OUT_W = 8,
  localparam int DAT_W = ADC_W + 1,
  localparam int EW    = ((CM_W > DAT_W) ? CM_W : DAT_W) + 2
) (
  input  sel_mode_e               mode_i,
  input  logic signed [DAT_W-1:0] dat_i,
  input  logic                    kill_i,
  input  logic signed [CM_W-1:0]  cm_i,
  input  logic [ADC_W-1:0]        th1_i,
  input  logic [ADC_W-1:0]        thw_i,
  input  logic [ADC_W-1:0]        thr_i,
  input  logic [ADC_W-1:0]        tch_i,
  output logic                    sel_o,
  output logic                    rec_o,
  output logic signed [OUT_W-1:0] corr_o,
  output logic                    hit_o
);
  localparam int OMAX = 2 ** (OUT_W - 1) - 1;
  localparam int OMIN = -(2 ** (OUT_W - 1));

  logic signed [EW-1:0] d_e, cm_e, diff, th1_e, thw_e, thr_e;
  logic in_coarse, in_symm;

  always_comb begin
    d_e   = EW'(dat_i);
    cm_e  = EW'(cm_i);
    diff  = d_e - cm_e;
    th1_e = $signed({{(EW-ADC_W){1'b0}}, th1_i});
    thw_e = $signed({{(EW-ADC_W){1'b0}}, thw_i});
    thr_e = $signed({{(EW-ADC_W){1'b0}}, thr_i});
    // coarse window leans negative: [-2*th1, th1]
    in_coarse = (d_e >= -(th1_e <<< 1)) && (d_e <= th1_e);
    in_symm   = (diff >= -thw_e) && (diff <= thw_e);
    sel_o = !kill_i && ((mode_i == SEL_COARSE) ? in_coarse : in_symm);
    rec_o = !kill_i && (d_e <= thr_e) && (diff > thr_e);

    if (kill_i)                          corr_o = '0;
    else if (diff > $signed(EW'(OMAX)))  corr_o = OUT_W'(OMAX);
    else if (diff < $signed(EW'(OMIN)))  corr_o = OUT_W'(OMIN);
    else                                 corr_o = diff[OUT_W-1:0];

    hit_o = !kill_i && (corr_o > $signed({1'b0, tch_i}));
  end
endmodule

// File: rtl/cms_divider.sv
module cms_divider #(
  parameter int NUM_W = 15,
  parameter int DEN_W = 8,
  localparam int STP_W = $clog2(NUM_W + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    go_i,
  input  logic signed [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0]        den_i,
  output logic                    done_o,
  output logic signed [NUM_W-1:0] quo_o
);
  logic [NUM_W-1:0] mag_q, rem_q, quo_q, rem_sh, rem_nx, quo_nx, den_x;
  logic [DEN_W-1:0] den_q;
  logic [STP_W-1:0] step_q;
  logic             neg_q, busy_q, ge;

  always_comb begin
    den_x  = NUM_W'(den_q);
    rem_sh = {rem_q[NUM_W-2:0], mag_q[NUM_W-1]};
    ge     = rem_sh >= den_x;
    rem_nx = ge ? rem_sh - den_x : rem_sh;
    quo_nx = {quo_q[NUM_W-2:0], ge};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mag_q <= '0; rem_q <= '0; quo_q <= '0; den_q <= '0;
      step_q <= '0; neg_q <= 1'b0; busy_q <= 1'b0;
      done_o <= 1'b0; quo_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        if (den_i == '0) begin
          quo_o  <= '0;
          done_o <= 1'b1;
        end else begin
          neg_q  <= num_i[NUM_W-1];
          mag_q  <= num_i[NUM_W-1] ? NUM_W'(-num_i) : NUM_W'(num_i);
          rem_q  <= '0;
          quo_q  <= '0;
          den_q  <= den_i;
          step_q <= STP_W'(NUM_W);
          busy_q <= 1'b1;
        end
      end else if (busy_q) begin
        rem_q  <= rem_nx;
        quo_q  <= quo_nx;
        mag_q  <= mag_q << 1;
        step_q <= step_q - 1'b1;
        if (step_q == STP_W'(1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
          quo_o  <= neg_q ? -$signed(quo_nx) : $signed(quo_nx);
        end
      end
    end
  end

  assert_zero_den_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && den_i == '0) |=> (done_o && quo_o == '0));
endmodule

// File: rtl/cms_unit.sv
module cms_unit import cms_pkg::*; #(
  parameter int NCH   = 128,
  parameter int ADC_W = 6,
  parameter int CM_W  = 8,
  parameter int OUT_W = 8,
  localparam int IDX_W = $clog2(NCH),
  localparam int CNT_W = $clog2(NCH + 1),
  localparam int DAT_W = ADC_W + 1,
  localparam int SUM_W = DAT_W + IDX_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [IDX_W-1:0]        cfg_ch_i,
  input  logic [ADC_W-1:0]        cfg_ped_i,
  input  logic [ADC_W-1:0]        cfg_thr_i,
  input  logic                    cfg_kill_i,
  input  logic                    cms_en_i,
  input  logic [ADC_W-1:0]        th1_i,
  input  logic [ADC_W-1:0]        th2_i,
  input  logic [ADC_W-1:0]        th3_i,
  input  logic [ADC_W-1:0]        thr_i,
  input  logic [CNT_W-1:0]        ncm_i,
  input  logic [CNT_W-1:0]        nrec_i,
  input  logic                    smp_valid_i,
  input  logic [IDX_W-1:0]        smp_ch_i,
  input  logic [ADC_W-1:0]        smp_adc_i,
  output logic                    busy_o,
  output logic                    out_valid_o,
  output logic [IDX_W-1:0]        out_ch_o,
  output logic signed [OUT_W-1:0] out_data_o,
  output logic                    out_hit_o,
  output logic                    done_o,
  output logic signed [CM_W-1:0]  cm_o,
  output logic [CNT_W-1:0]        n3_o,
  output logic [CNT_W-1:0]        nsig_o,
  output logic [CNT_W-1:0]        nrec_o
);
  localparam int CM_MAX = 2 ** (CM_W - 1) - 1;
  localparam int CM_MIN = -(2 ** (CM_W - 1));

  cms_state_e st_q;
  logic [IDX_W-1:0]        idx_q;
  logic signed [SUM_W-1:0] acc_sum_q;
  logic [CNT_W-1:0]        acc_cnt_q, n3_q, nrec_q, nsig_q;
  logic signed [CM_W-1:0]  cm1_q, cm2_q, cm3_q, cmf_q, cm_ref, cm_sat;
  logic                    div_go_q, div_done;
  logic signed [SUM_W-1:0] div_q;
  logic                    last, smp_we;

  logic signed [DAT_W-1:0] rd_dat;
  logic [ADC_W-1:0]        rd_thr, thw;
  logic                    rd_kill, sel, rec, hit;
  logic signed [OUT_W-1:0] corr;
  sel_mode_e               mode;

  assign last   = idx_q == IDX_W'(NCH - 1);
  assign busy_o = st_q != ST_IDLE;
  assign smp_we = smp_valid_i && (st_q == ST_IDLE);

  cms_chan_store #(.NCH(NCH), .ADC_W(ADC_W)) u_store (
    .clk_i, .cfg_we_i, .cfg_ch_i, .cfg_ped_i, .cfg_thr_i, .cfg_kill_i,
    .smp_we_i(smp_we), .smp_ch_i, .smp_adc_i,
    .rd_idx_i(idx_q), .rd_dat_o(rd_dat), .rd_thr_o(rd_thr), .rd_kill_o(rd_kill)
  );

  always_comb begin
    mode   = (st_q == ST_P1) ? SEL_COARSE : SEL_SYMM;
    thw    = (st_q == ST_P2) ? th2_i : th3_i;
    unique case (st_q)
      ST_P2:   cm_ref = cm1_q;
      ST_P3:   cm_ref = cm2_q;
      ST_REC:  cm_ref = cm3_q;
      ST_OUT:  cm_ref = cmf_q;
      default: cm_ref = '0;
    endcase
  end

  cms_chan_eval #(.ADC_W(ADC_W), .CM_W(CM_W), .OUT_W(OUT_W)) u_eval (
    .mode_i(mode), .dat_i(rd_dat), .kill_i(rd_kill), .cm_i(cm_ref),
    .th1_i, .thw_i(thw), .thr_i, .tch_i(rd_thr),
    .sel_o(sel), .rec_o(rec), .corr_o(corr), .hit_o(hit)
  );

  cms_divider #(.NUM_W(SUM_W), .DEN_W(CNT_W)) u_div (
    .clk_i, .rst_ni, .go_i(div_go_q), .num_i(acc_sum_q), .den_i(acc_cnt_q),
    .done_o(div_done), .quo_o(div_q)
  );

  always_comb begin
    if (div_q > $signed(SUM_W'(CM_MAX)))      cm_sat = CM_W'(CM_MAX);
    else if (div_q < $signed(SUM_W'(CM_MIN))) cm_sat = CM_W'(CM_MIN);
    else                                      cm_sat = div_q[CM_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; idx_q <= '0;
      acc_sum_q <= '0; acc_cnt_q <= '0; div_go_q <= 1'b0;
      cm1_q <= '0; cm2_q <= '0; cm3_q <= '0; cmf_q <= '0;
      n3_q <= '0; nrec_q <= '0; nsig_q <= '0;
      out_valid_o <= 1'b0; out_ch_o <= '0; out_data_o <= '0; out_hit_o <= 1'b0;
      done_o <= 1'b0; cm_o <= '0; n3_o <= '0; nsig_o <= '0; nrec_o <= '0;
    end else begin
      div_go_q    <= 1'b0;
      out_valid_o <= 1'b0;
      done_o      <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          idx_q <= '0;
          acc_sum_q <= '0;
          acc_cnt_q <= '0;
          if (smp_valid_i && smp_ch_i == IDX_W'(NCH - 1)) st_q <= ST_P1;
        end
        ST_P1, ST_P2, ST_P3: begin
          if (sel) begin
            acc_sum_q <= acc_sum_q + SUM_W'(rd_dat);
            acc_cnt_q <= acc_cnt_q + 1'b1;
          end
          idx_q <= idx_q + 1'b1;
          if (last) begin
            div_go_q <= 1'b1;
            st_q <= (st_q == ST_P1) ? ST_D1 : (st_q == ST_P2) ? ST_D2 : ST_D3;
          end
        end
        ST_D1, ST_D2, ST_D3: begin
          if (div_done) begin
            acc_sum_q <= '0;
            acc_cnt_q <= '0;
            idx_q <= '0;
            if (st_q == ST_D1) begin
              cm1_q <= cm_sat; st_q <= ST_P2;
            end else if (st_q == ST_D2) begin
              cm2_q <= cm_sat; st_q <= ST_P3;
            end else begin
              cm3_q <= cm_sat; n3_q <= acc_cnt_q; nrec_q <= '0; st_q <= ST_REC;
            end
          end
        end
        ST_REC: begin
          if (rec) nrec_q <= nrec_q + 1'b1;
          idx_q <= idx_q + 1'b1;
          if (last) st_q <= ST_DEC;
        end
        ST_DEC: begin
          cmf_q  <= (cms_en_i && n3_q >= ncm_i && nrec_q <= nrec_i) ? cm3_q : '0;
          nsig_q <= '0;
          idx_q  <= '0;
          st_q   <= ST_OUT;
        end
        ST_OUT: begin
          out_valid_o <= 1'b1;
          out_ch_o    <= idx_q;
          out_data_o  <= corr;
          out_hit_o   <= hit;
          nsig_q      <= nsig_q + CNT_W'(hit);
          idx_q       <= idx_q + 1'b1;
          if (last) begin
            done_o <= 1'b1;
            cm_o   <= cmf_q;
            n3_o   <= n3_q;
            nrec_o <= nrec_q;
            nsig_o <= nsig_q + CNT_W'(hit);
            st_q   <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_ch_order_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && $past(out_valid_o)) |-> out_ch_o == $past(out_ch_o) + IDX_W'(1));
  assert_cm_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (!cms_en_i || n3_o < ncm_i || nrec_o > nrec_i)) |-> cm_o == '0);
  assert_hit_positive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_hit_o |-> out_data_o > 0);
  assert_n3_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> n3_o <= CNT_W'(NCH));
endmodule

// File: tb/cms_unit_tb.sv
`timescale 1ns/1ps
module cms_unit_tb;
  localparam int NCH = 128;

  typedef struct packed {
    logic signed [7:0] offs;
    logic [7:0]        amp;
    logic [7:0]        sstr;
    logic [7:0]        kstr;
    logic              cms;
    logic [7:0]        ncm;
    logic [7:0]        nrec;
    logic              poke;
  } vec_t;

  // offset, signal amp, signal stride, kill stride, cms, ncm, nrec, poke-while-busy
  localparam vec_t VECS [8] = '{
    '{ 8'sd0,  8'd20, 8'd16, 8'd0,  1'b0, 8'd64,  8'd31,  1'b0},
    '{ 8'sd4,  8'd20, 8'd10, 8'd0,  1'b1, 8'd64,  8'd31,  1'b0},
    '{-8'sd6,  8'd20, 8'd8,  8'd13, 1'b1, 8'd64,  8'd31,  1'b1},
    '{-8'sd8,  8'd10, 8'd4,  8'd0,  1'b1, 8'd64,  8'd31,  1'b0},
    '{-8'sd8,  8'd10, 8'd4,  8'd0,  1'b1, 8'd64,  8'd40,  1'b0},
    '{ 8'sd3,  8'd20, 8'd8,  8'd1,  1'b1, 8'd0,   8'd127, 1'b0},
    '{ 8'sd40, 8'd0,  8'd0,  8'd0,  1'b1, 8'd0,   8'd127, 1'b0},
    '{ 8'sd3,  8'd20, 8'd8,  8'd3,  1'b1, 8'd100, 8'd31,  1'b0}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_we_i = 1'b0, cfg_kill_i = 1'b0, cms_en_i = 1'b0, smp_valid_i = 1'b0;
  logic [6:0] cfg_ch_i = '0, smp_ch_i = '0;
  logic [5:0] cfg_ped_i = '0, cfg_thr_i = '0, smp_adc_i = '0;
  logic [5:0] th1_i = 6'd5, th2_i = 6'd5, th3_i = 6'd5, thr_i = 6'd5;
  logic [7:0] ncm_i = 8'd64, nrec_i = 8'd31;
  logic busy_o, out_valid_o, out_hit_o, done_o;
  logic [6:0] out_ch_o;
  logic signed [7:0] out_data_o, cm_o;
  logic [7:0] n3_o, nsig_o, nrec_o;

  always #4 clk_i = ~clk_i;

  cms_unit u_dut (.*);

  int checks = 0, failures = 0;
  int adc_v[NCH], ped_v[NCH], tch_v[NCH], kill_v[NCH];
  int exp_d[NCH], exp_h[NCH], exp_cm, exp_n3, exp_nrec, exp_nsig;
  int got_d[NCH], got_h[NCH];
  int n_out = 0, ord_err = 0, done_cnt = 0, nxt_ch = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (out_valid_o) begin
      if (int'(out_ch_o) != nxt_ch) ord_err++;
      nxt_ch = int'(out_ch_o) + 1;
      got_d[out_ch_o] = int'(out_data_o);
      got_h[out_ch_o] = int'(out_hit_o);
      n_out++;
    end
    if (done_o) done_cnt++;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic void build(input int k);
    vec_t v = VECS[k];
    for (int i = 0; i < NCH; i++) begin
      int n, a;
      ped_v[i]  = 20 + (i % 11);
      tch_v[i]  = 3 + (i % 4);
      kill_v[i] = (v.kstr != 0 && (i % int'(v.kstr)) == 0) ? 1 : 0;
      n = ((i * 7 + k) % 5) - 2;
      a = ped_v[i] + int'(v.offs) + n;
      if (v.sstr != 0 && (i % int'(v.sstr)) == 0) a += int'(v.amp);
      adc_v[i] = (a < 0) ? 0 : (a > 63) ? 63 : a;
    end
  endfunction

  function automatic int avg(input int s, input int c);
    return (c == 0) ? 0 : s / c;
  endfunction

  function automatic void model(input vec_t v);
    int d[NCH];
    int s, c, cm1, cm2, cm3, cmf;
    for (int i = 0; i < NCH; i++) d[i] = adc_v[i] - ped_v[i];
    s = 0; c = 0;
    for (int i = 0; i < NCH; i++)
      if (!kill_v[i] && d[i] >= -10 && d[i] <= 5) begin s += d[i]; c++; end
    cm1 = avg(s, c);
    s = 0; c = 0;
    for (int i = 0; i < NCH; i++)
      if (!kill_v[i] && d[i] - cm1 >= -5 && d[i] - cm1 <= 5) begin s += d[i]; c++; end
    cm2 = avg(s, c);
    s = 0; c = 0;
    for (int i = 0; i < NCH; i++)
      if (!kill_v[i] && d[i] - cm2 >= -5 && d[i] - cm2 <= 5) begin s += d[i]; c++; end
    cm3 = avg(s, c);
    exp_n3 = c;
    exp_nrec = 0;
    for (int i = 0; i < NCH; i++)
      if (!kill_v[i] && d[i] <= 5 && d[i] - cm3 > 5) exp_nrec++;
    cmf = (v.cms && exp_n3 >= int'(v.ncm) && exp_nrec <= int'(v.nrec)) ? cm3 : 0;
    exp_cm = cmf;
    exp_nsig = 0;
    for (int i = 0; i < NCH; i++) begin
      int x = d[i] - cmf;
      x = (x > 127) ? 127 : (x < -128) ? -128 : x;
      exp_d[i] = kill_v[i] ? 0 : x;
      exp_h[i] = (!kill_v[i] && x > tch_v[i]) ? 1 : 0;
      exp_nsig += exp_h[i];
    end
  endfunction

  task automatic load_cfg();
    for (int i = 0; i < NCH; i++) begin
      @(negedge clk_i);
      cfg_we_i = 1'b1; cfg_ch_i = 7'(i);
      cfg_ped_i = 6'(ped_v[i]); cfg_thr_i = 6'(tch_v[i]); cfg_kill_i = kill_v[i][0];
    end
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic run_event(input int k, input bit rev);
    vec_t v = VECS[k];
    string tg;
    build(k);
    load_cfg();
    model(v);
    cms_en_i = v.cms; ncm_i = v.ncm; nrec_i = v.nrec;
    n_out = 0; ord_err = 0; done_cnt = 0; nxt_ch = 0;
    for (int j = 0; j < NCH; j++) begin
      int ch = (rev && j < NCH - 1) ? (NCH - 2 - j) : j;
      @(negedge clk_i);
      smp_valid_i = 1'b1; smp_ch_i = 7'(ch); smp_adc_i = 6'(adc_v[ch]);
    end
    @(negedge clk_i);
    smp_valid_i = 1'b0;
    chk(busy_o == 1'b1, "R8 busy after last sample", int'(busy_o), 1);
    if (v.poke) begin
      repeat (3) @(negedge clk_i);
      chk(busy_o == 1'b1, "R8 busy during poke", int'(busy_o), 1);
      smp_valid_i = 1'b1; smp_ch_i = 7'd5; smp_adc_i = 6'd63;
      @(negedge clk_i);
      smp_valid_i = 1'b0;
    end
    while (done_cnt == 0) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    for (int i = 0; i < NCH; i++) begin
      tg = kill_v[i] ? "R2 killed channel" : (!v.cms ? "R1 pedestal pass" :
           (v.poke ? "R8 ignored sample" : "R7 corrected value"));
      chk(got_d[i] == exp_d[i], tg, got_d[i], exp_d[i]);
      chk(got_h[i] == exp_h[i], kill_v[i] ? "R2 killed hit" : "R7 hit flag", got_h[i], exp_h[i]);
    end
    tg = (k == 5 || k == 6) ? "R3 empty selection cm" : "R6 applied cm";
    chk(int'(cm_o) == exp_cm, tg, int'(cm_o), exp_cm);
    chk(int'(n3_o) == exp_n3, "R4 n3", int'(n3_o), exp_n3);
    chk(int'(nrec_o) == exp_nrec, "R5 nrec", int'(nrec_o), exp_nrec);
    chk(int'(nsig_o) == exp_nsig, "R7 nsig", int'(nsig_o), exp_nsig);
    chk(n_out == NCH && ord_err == 0, "R9 output order", n_out, NCH);
    chk(done_cnt == 1, "R9 single done", done_cnt, 1);
    repeat (5) @(negedge clk_i);
    chk(int'(cm_o) == exp_cm && int'(n3_o) == exp_n3, "R9 counters held", int'(cm_o), exp_cm);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(busy_o == 1'b0 && out_valid_o == 1'b0 && done_o == 1'b0, "R10 reset flags",
        int'({busy_o, out_valid_o, done_o}), 0);
    chk(cm_o == 0 && n3_o == 0 && nsig_o == 0 && nrec_o == 0, "R10 reset counters",
        int'(n3_o) + int'(nsig_o) + int'(nrec_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(busy_o == 1'b0, "R10 idle after reset", int'(busy_o), 0);

    for (int k = 0; k < 8; k++) run_event(k, 1'b0);

    // directed: channels 126..0 arrive in reverse, then 127 closes the event
    run_event(1, 1'b1);
    // directed: recovered count just over and under the gate limit
    build(3); model(VECS[3]);
    chk(exp_nrec > 31 && exp_nrec <= 40, "R5 gate scenario sanity", exp_nrec, 32);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule